// File: doc/BRIEF.md
# Exclusive Handshake Mixer

The mixer joins two passive four-phase channels, called `a` and `b`, onto a single active four-phase channel `c`. When one of the passive requests goes high, the block raises the request on `c`. It then passes the acknowledge from `c` back to the port that started the cycle. This holds for both the rising and the falling half of the handshake. The other port sees no acknowledge at all during that cycle.

The environment must never hold both passive requests high together. The block is a clocked model of this mixer, and it watches for that condition. If both requests are sampled high in one cycle, a sticky error flag goes high and stays high until reset. While both requests are high and no cycle is in progress, no new `c` cycle is started.

The port that started a cycle keeps ownership of `c` until its own acknowledge has returned low. A request from the other port that arrives during the return-to-zero phase waits until that point. Each step of the handshake takes exactly one clock edge, because every output comes from a register.

Top module: `hs_mixer`

## Requirements
- R1: After synchronous reset, `c_req`, `a_ack`, `b_ack` and `excl_err` are all low.
- R2: When no cycle is in progress, a high `a_req` (with `b_req` low) makes `c_req` high one clock edge later; `b_req` alone does the same for port b.
- R3: While `c_req` is high and the owner's acknowledge is low, a high `c_ack` makes the owner's acknowledge high one clock edge later.
- R4: While the owner's acknowledge is high, the owner lowering its request makes `c_req` low one clock edge later.
- R5: After `c_req` has fallen, a low `c_ack` makes the owner's acknowledge low one clock edge later, which ends the cycle.
- R6: Only the port that started the cycle receives an acknowledge; the other acknowledge stays low through the whole cycle, and `a_ack` and `b_ack` are never high together.
- R7: A passive acknowledge rises only on an edge where `c_ack` was high; it stays low for any number of cycles of `c` latency before that.
- R8: With both passive requests and `c_ack` low while no cycle is in progress, `c_req` stays low.
- R9: `excl_err` goes high one clock edge after both passive requests are sampled high together, and stays high until reset.
- R10: When both passive requests are high and no cycle is in progress, no `c` cycle is started.
- R11: A request from the non-owning port that rises after the owner's request has fallen starts its `c` cycle only on the clock edge after the owner's acknowledge has fallen.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| a_req | input | 1 | Request from passive port a |
| a_ack | output | 1 | Acknowledge to passive port a |
| b_req | input | 1 | Request from passive port b |
| b_ack | output | 1 | Acknowledge to passive port b |
| c_req | output | 1 | Request on the active port c |
| c_ack | input | 1 | Acknowledge from active port c |
| excl_err | output | 1 | Sticky flag: both passive requests were seen high together |

## Verification
A corrupted owner record would send the acknowledge to the wrong port. This shows up on the first `c` acknowledge after the fault, one edge after `c_ack` rises, as a high acknowledge on the idle port. A phase register stuck or skipped would show one edge after the triggering input changes: `c_req` would fail to follow the owner's request, or an acknowledge would rise without `c_ack` having been high. The tests vary the `c` latency in both phases, so a step that ignores its guard becomes visible in the cycle where that guard is still false.

// File: rtl/hs_mixer_pkg.sv
package hs_mixer_pkg;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_RISE = 2'd1,
        PH_HOLD = 2'd2,
        PH_FALL = 2'd3
    } mix_phase_t;

    typedef enum logic [1:0] {
        OWN_NONE = 2'd0,
        OWN_A    = 2'd1,
        OWN_B    = 2'd2
    } mix_owner_t;

    typedef struct packed {
        mix_phase_t phase;
        mix_owner_t owner;
        logic       creq;
        logic       ack;
    } mix_state_t;

    localparam mix_state_t MIX_RESET = '{phase: PH_IDLE, owner: OWN_NONE, creq: 1'b0, ack: 1'b0};

    function automatic logic owner_req(mix_owner_t own, logic a, logic b);
        case (own)
            OWN_A:   return a;
            OWN_B:   return b;
            default: return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/hs_mixer_fsm.sv
module hs_mixer_fsm
    import hs_mixer_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       a_req,
    input  logic       b_req,
    input  logic       c_ack,
    output mix_state_t st
);
    mix_state_t nxt;
    logic       oreq;

    assign oreq = owner_req(st.owner, a_req, b_req);

    always_comb begin
        nxt = st;
        unique case (st.phase)
            PH_IDLE: begin
                if (a_req && !b_req) begin
                    nxt.phase = PH_RISE; nxt.owner = OWN_A; nxt.creq = 1'b1;
                end else if (b_req && !a_req) begin
                    nxt.phase = PH_RISE; nxt.owner = OWN_B; nxt.creq = 1'b1;
                end
            end
            PH_RISE: if (c_ack) begin
                nxt.phase = PH_HOLD; nxt.ack = 1'b1;
            end
            PH_HOLD: if (!oreq) begin
                nxt.phase = PH_FALL; nxt.creq = 1'b0;
            end
            PH_FALL: if (!c_ack) begin
                nxt.phase = PH_IDLE; nxt.ack = 1'b0; nxt.owner = OWN_NONE;
            end
            default: nxt = MIX_RESET;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) st <= MIX_RESET;
        else     st <= nxt;
    end

    // R2: an exclusive request in idle starts a c cycle
    p_start_r2: assert property (@(posedge clk) disable iff (rst)
        (st.phase == PH_IDLE && (a_req ^ b_req)) |=> st.creq);
    // R4: owner release drops c request
    p_release_r4: assert property (@(posedge clk) disable iff (rst)
        (st.phase == PH_HOLD && !oreq) |=> !st.creq);
    // R8: quiet inputs keep c request low
    p_quiet_r8: assert property (@(posedge clk) disable iff (rst)
        (st.phase == PH_IDLE && !a_req && !b_req && !c_ack) |=> !st.creq);
    // R10: contention in idle starts nothing
    p_contend_r10: assert property (@(posedge clk) disable iff (rst)
        (st.phase == PH_IDLE && a_req && b_req) |=> !st.creq);
endmodule

// File: rtl/hs_mixer_excl_mon.sv
module hs_mixer_excl_mon (
    input  logic clk,
    input  logic rst,
    input  logic a_req,
    input  logic b_req,
    output logic err
);
    always_ff @(posedge clk) begin
        if (rst) err <= 1'b0;
        else if (a_req && b_req) err <= 1'b1;
    end

    // R9: error is sticky
    p_sticky_r9: assert property (@(posedge clk) disable iff (rst)
        err |=> err);
    // R9: contention raises error
    p_flag_r9: assert property (@(posedge clk) disable iff (rst)
        (a_req && b_req) |=> err);
endmodule

// File: rtl/hs_mixer_route.sv
module hs_mixer_route
    import hs_mixer_pkg::*;
(
    input  mix_state_t st,
    output logic       a_ack,
    output logic       b_ack,
    output logic       c_req
);
    assign a_ack = st.ack && (st.owner == OWN_A);
    assign b_ack = st.ack && (st.owner == OWN_B);
    assign c_req = st.creq;
endmodule

// File: rtl/hs_mixer.sv
module hs_mixer
    import hs_mixer_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic a_req,
    output logic a_ack,
    input  logic b_req,
    output logic b_ack,
    output logic c_req,
    input  logic c_ack,
    output logic excl_err
);
    mix_state_t st;

    hs_mixer_fsm u_fsm (
        .clk(clk), .rst(rst), .a_req(a_req), .b_req(b_req), .c_ack(c_ack), .st(st)
    );

    hs_mixer_route u_route (
        .st(st), .a_ack(a_ack), .b_ack(b_ack), .c_req(c_req)
    );

    hs_mixer_excl_mon u_mon (
        .clk(clk), .rst(rst), .a_req(a_req), .b_req(b_req), .err(excl_err)
    );

    // R6: acknowledges are exclusive
    p_one_ack_r6: assert property (@(posedge clk) disable iff (rst)
        !(a_ack && b_ack));
    // R7: no premature acknowledge
    p_ack_a_r7: assert property (@(posedge clk) disable iff (rst)
        $rose(a_ack) |-> $past(c_ack));
    p_ack_b_r7: assert property (@(posedge clk) disable iff (rst)
        $rose(b_ack) |-> $past(c_ack));
    // R3: c acknowledge is forwarded while c request is up
    p_fwd_r3: assert property (@(posedge clk) disable iff (rst)
        (c_req && c_ack && !a_ack && !b_ack) |=> (a_ack || b_ack));
endmodule

// File: tb/hs_mixer_tb_top.sv
module hs_mixer_tb_top;
    logic clk = 1'b0;
    logic rst;
    logic a_req, b_req, c_ack;
    logic a_ack, b_ack, c_req, excl_err;
    int   n_chk = 0;
    int   n_bad = 0;
    bit   done = 0;

    always #2 clk = ~clk;

    hs_mixer dut_i (
        .clk(clk), .rst(rst), .a_req(a_req), .a_ack(a_ack), .b_req(b_req),
        .b_ack(b_ack), .c_req(c_req), .c_ack(c_ack), .excl_err(excl_err)
    );

    task automatic chk(string req, logic act, logic exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic set_req(bit port_b, logic v);
        if (port_b) b_req = v; else a_req = v;
    endtask

    function automatic logic own_ack(bit port_b);
        return port_b ? b_ack : a_ack;
    endfunction

    function automatic logic oth_ack(bit port_b);
        return port_b ? a_ack : b_ack;
    endfunction

    task automatic do_reset();
        rst = 1'b1; a_req = 0; b_req = 0; c_ack = 0;
        step(); step();
        rst = 1'b0;
        step();
    endtask

    // Full four-phase transaction on one passive port with chosen c latencies
    task automatic xact(bit pb, int lat_up, int lat_dn);
        set_req(pb, 1'b1);
        step();
        chk("R2 c_req rises", c_req, 1'b1);
        for (int i = 0; i < lat_up; i++) begin
            step();
            chk("R7 no early ack", own_ack(pb), 1'b0);
        end
        c_ack = 1'b1;
        step();
        chk("R3 ack to owner", own_ack(pb), 1'b1);
        chk("R6 other ack low", oth_ack(pb), 1'b0);
        set_req(pb, 1'b0);
        step();
        chk("R4 c_req falls", c_req, 1'b0);
        for (int i = 0; i < lat_dn; i++) begin
            step();
            chk("R5 ack held until c_ack low", own_ack(pb), 1'b1);
        end
        c_ack = 1'b0;
        step();
        chk("R5 ack falls", own_ack(pb), 1'b0);
        chk("R6 other ack low", oth_ack(pb), 1'b0);
    endtask

    task automatic t_reset();
        do_reset();
        chk("R1 c_req", c_req, 1'b0);
        chk("R1 a_ack", a_ack, 1'b0);
        chk("R1 b_ack", b_ack, 1'b0);
        chk("R1 excl_err", excl_err, 1'b0);
    endtask

    task automatic t_directed();
        xact(1'b0, 0, 0);
        xact(1'b1, 3, 2);
        xact(1'b0, 5, 0);
    endtask

    task automatic t_random();
        for (int k = 0; k < 40; k++) begin
            xact(bit'($urandom_range(0, 1)), int'($urandom_range(0, 6)), int'($urandom_range(0, 6)));
            for (int i = 0; i < int'($urandom_range(0, 3)); i++) begin
                step();
                chk("R8 idle c_req low", c_req, 1'b0);
            end
        end
    endtask

    task automatic t_handover();
        a_req = 1; step();
        c_ack = 1; step();
        a_req = 0; step();
        b_req = 1; step();
        chk("R11 b waits", c_req, 1'b0);
        chk("R11 no b ack", b_ack, 1'b0);
        chk("R11 a ack held", a_ack, 1'b1);
        c_ack = 0; step();
        chk("R11 a ack falls", a_ack, 1'b0);
        chk("R11 b not yet started", c_req, 1'b0);
        step();
        chk("R11 b starts", c_req, 1'b1);
        c_ack = 1; step();
        chk("R6 b owns ack", b_ack, 1'b1);
        chk("R6 a ack low", a_ack, 1'b0);
        b_req = 0; step();
        c_ack = 0; step();
        chk("R5 b ack falls", b_ack, 1'b0);
        chk("R9 no error in legal handover", excl_err, 1'b0);
    endtask

    task automatic t_contention();
        step();
        chk("R8 quiet", c_req, 1'b0);
        a_req = 1; b_req = 1; step();
        chk("R10 no start", c_req, 1'b0);
        chk("R9 err set", excl_err, 1'b1);
        a_req = 0; b_req = 0; step();
        chk("R9 err sticky", excl_err, 1'b1);
        chk("R8 c_req low", c_req, 1'b0);
        xact(1'b0, 1, 1);
        chk("R9 err still sticky", excl_err, 1'b1);
        do_reset();
        chk("R1 err cleared", excl_err, 1'b0);
    endtask

    initial begin
        t_reset();
        t_directed();
        t_random();
        t_handover();
        t_contention();
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_chk++; n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule